// File: doc/BRIEF.md
# Single-Lane Main-Link Stream Framer

This block produces the main-link symbol stream for one DisplayPort lane carrying a fixed test picture (800x600 at 60 Hz, 24 bits per pixel, by default). On every clock it emits two 8-bit symbols. Each symbol has a K flag that marks it as a control code, and the stream is meant to feed an 8b/10b encoder. Pixels come from a built-in pattern. The symbols are not scrambled.

After the link comes up, the framer sends idle lines. Each idle line carries one blanking-start group that says no video is present. Once a programmable number of cycles has passed, it switches to video at the next line boundary, starting with frame line 0. Every line has a fixed length in symbols. An active line opens with a blanking-end code and then carries transfer units of 54 symbols each, holding 8 pixels per unit. Its blanking opens with a blanking-start code, or with a scrambler-reset code in its place, and this is followed by the VB-ID, Mvid and Maud bytes, each sent four times. The first line of vertical blanking also carries the stream attribute packet.

Top module: `dpf_stream_framer`

## Requirements
- R1: While reset is asserted, both output slots are data 0x00 with K clear.
- R2: In idle, each line has exactly one blanking-start code, at symbol position BSP = 1 + 54*(H_ACT/8). It is followed by VB-ID 0x09 (bit 3 no video, bit 0 vertical blank) four times, then 0x00 four times, then 0x00 four times. There is no blanking-end code, and all other symbols are data 0x00.
- R3: Video starts on the first line boundary reached once link_up has been high for at least IDLE_CYC cycles. The first video symbol is blanking-end (K, 0xFB) on line 0.
- R4: Blanking-start (K, 0xBC) and scrambler-reset (K, 0x1C) codes are counted together. Every SR_EVERY-th one is scrambler-reset, and the others are blanking-start.
- R5: In video, the three bytes after the BS/SR code are VB-ID ×4, then Mvid[7:0] ×4, then Maud[7:0] = 0x00 ×4.
- R6: VB-ID is 0x01 on the last active line and on every vertical-blanking line, and 0x00 on other lines. Blanking-end appears at position 0 of each active line and never on a blanking line.
- R7: Each transfer unit consists of 24 pixel data symbols, then fill-start (K, 0xFE), then 28 data 0x00, then fill-end (K, 0xF7).
- R8: Pixel x of line y is sent as three bytes in the order x[7:0], y[7:0], x^y, where x = 8*unit + index within the unit.
- R9: The attribute packet is sent once per frame, on line V_ACT only, at position BSP+13. It consists of two K 0x5C codes, 24 bytes and a K 0xFD code. The bytes are: Mvid[23:0] (most significant byte first), h-total, v-total, {h-polarity, h-sync width}, h-start, v-start, {v-polarity, v-sync width}, h-width, v-height, each as 16 bits high byte first; then Nvid[23:0], MISC0 and MISC1.
- R10: In the attribute packet, h-start equals H_SW+H_BP and v-start equals V_SW+V_BP. Mvid = 0x012F68, Nvid = 0x080000 and MISC0 = 0x21 (synchronous clock, 8 bits per component).
- R11: In each output word, the lower slot holds the earlier symbol. Any symbol not covered above is data 0x00, and a K flag appears only with the seven codes listed in these requirements.
- R12: While link_up is low, the framer holds its restart state: from the second cycle on, both slots are data 0x00. When link_up rises again, idle, the cycle counter and the SR counting all start over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock (two symbols per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | High while the trained link is usable; low restarts the framer |
| sym_lo | output | 8 | Earlier symbol of the pair |
| k_lo | output | 1 | Control flag for sym_lo |
| sym_hi | output | 8 | Later symbol of the pair |
| k_hi | output | 1 | Control flag for sym_hi |

## Verification
The bench uses a shrunken timing: a 16-pixel line, 3 active lines, 6 total lines, 160-symbol lines, 200 idle cycles and an SR period of 4. It compares every symbol of the stream against a model built from these requirements. The sweep covers the whole idle period, the idle-to-video handover and two full frames, so it tells apart BE/BS placement, the VB-ID value on active lines versus the last active line versus blanking lines, and the MSA line versus the others. The SR count carries across the idle/video boundary and across line wraps. A link drop in the middle of a frame, followed by a second run, shows that counting restarts rather than resumes.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  localparam logic [7:0] K_BS = 8'hBC;
  localparam logic [7:0] K_BE = 8'hFB;
  localparam logic [7:0] K_SR = 8'h1C;
  localparam logic [7:0] K_FS = 8'hFE;
  localparam logic [7:0] K_FE = 8'hF7;
  localparam logic [7:0] K_SS = 8'h5C;
  localparam logic [7:0] K_SE = 8'hFD;

  localparam int TU_SYMS   = 54;
  localparam int TU_DATA   = 24;
  localparam int TU_PIX    = 8;
  localparam int VB_REP    = 4;
  localparam int MSA_BYTES = 24;
  localparam int MSA_SYMS  = MSA_BYTES + 3;

  function automatic sym_t kcode(input logic [7:0] code);
    sym_t s;
    s.k = 1'b1;
    s.d = code;
    return s;
  endfunction

  // colour component c of pixel (x, y): 0 -> x, 1 -> y, 2 -> x^y
  function automatic logic [7:0] pix_byte(input int x, input int y, input int c);
    logic [7:0] xb;
    logic [7:0] yb;
    xb = 8'(x);
    yb = 8'(y);
    case (c)
      0:       return xb;
      1:       return yb;
      default: return xb ^ yb;
    endcase
  endfunction

endpackage

// File: rtl/dpf_timebase.sv
module dpf_timebase #(
  parameter int LINE_SYM = 7128,
  parameter int V_TOT    = 628,
  parameter int IDLE_CYC = 65536,
  localparam int PW = $clog2(LINE_SYM),
  localparam int LW = $clog2(V_TOT),
  localparam int IW = $clog2(IDLE_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up,
  output logic [PW-1:0] pos,
  output logic [LW-1:0] line,
  output logic          video
);

  logic [IW-1:0] idle_cnt;
  logic          line_end;

  assign line_end = (pos == PW'(LINE_SYM - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      line     <= '0;
      video    <= 1'b0;
      idle_cnt <= '0;
    end else if (!link_up) begin
      pos      <= '0;
      line     <= '0;
      video    <= 1'b0;
      idle_cnt <= '0;
    end else begin
      if (idle_cnt != IW'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
      if (line_end) begin
        pos <= '0;
        if (video) begin
          line <= (line == LW'(V_TOT - 1)) ? '0 : line + 1'b1;
        end else if (idle_cnt == IW'(IDLE_CYC)) begin
          video <= 1'b1;
          line  <= '0;
        end
      end else begin
        pos <= pos + PW'(2);
      end
    end
  end

endmodule

// File: rtl/dpf_sr_track.sv
module dpf_sr_track #(
  parameter int SR_EVERY = 512,
  localparam int SW = (SR_EVERY > 1) ? $clog2(SR_EVERY) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic bs_any,
  output logic sr_now
);

  logic [SW-1:0] cnt;

  assign sr_now = (cnt == SW'(SR_EVERY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!link_up)   cnt <= '0;
    else if (bs_any)     cnt <= sr_now ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/dpf_slot_gen.sv
module dpf_slot_gen
  import dpf_pkg::*;
#(
  parameter int          SLOT     = 0,
  parameter int          H_ACT    = 800,
  parameter int          V_ACT    = 600,
  parameter int          H_TOT    = 1056,
  parameter int          H_SW     = 128,
  parameter int          H_BP     = 88,
  parameter bit          H_POL    = 1'b0,
  parameter int          V_TOT    = 628,
  parameter int          V_SW     = 4,
  parameter int          V_BP     = 23,
  parameter bit          V_POL    = 1'b0,
  parameter int          LINE_SYM = 7128,
  parameter logic [23:0] MVID     = 24'h012F68,
  parameter logic [23:0] NVID     = 24'h080000,
  parameter logic [7:0]  MISC0    = 8'h21,
  parameter logic [7:0]  MISC1    = 8'h00,
  localparam int PW = $clog2(LINE_SYM),
  localparam int LW = $clog2(V_TOT)
) (
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] line,
  input  logic          video,
  input  logic          sr_now,
  output sym_t          sym,
  output logic          bs_ev,
  output logic          be_ev,
  output logic          sr_ev
);

  localparam int TUS     = H_ACT / TU_PIX;
  localparam int BS_POS  = 1 + TUS * TU_SYMS;
  localparam int GRP_END = BS_POS + 1 + 3 * VB_REP;
  localparam int MSA_END = GRP_END + MSA_SYMS;

  localparam logic [15:0] HT16 = 16'(H_TOT);
  localparam logic [15:0] VT16 = 16'(V_TOT);
  localparam logic [15:0] HA16 = 16'(H_ACT);
  localparam logic [15:0] VA16 = 16'(V_ACT);
  localparam logic [15:0] HS16 = 16'(H_SW + H_BP);
  localparam logic [15:0] VS16 = 16'(V_SW + V_BP);
  localparam logic [15:0] HW16 = {H_POL, 15'(H_SW)};
  localparam logic [15:0] VW16 = {V_POL, 15'(V_SW)};

  function automatic logic [7:0] msa_byte(input int i);
    case (i)
      0:  return MVID[23:16];
      1:  return MVID[15:8];
      2:  return MVID[7:0];
      3:  return HT16[15:8];
      4:  return HT16[7:0];
      5:  return VT16[15:8];
      6:  return VT16[7:0];
      7:  return HW16[15:8];
      8:  return HW16[7:0];
      9:  return HS16[15:8];
      10: return HS16[7:0];
      11: return VS16[15:8];
      12: return VS16[7:0];
      13: return VW16[15:8];
      14: return VW16[7:0];
      15: return HA16[15:8];
      16: return HA16[7:0];
      17: return VA16[15:8];
      18: return VA16[7:0];
      19: return NVID[23:16];
      20: return NVID[15:8];
      21: return NVID[7:0];
      22: return MISC0;
      default: return MISC1;
    endcase
  endfunction

  always_comb begin
    int  p;
    int  lin;
    int  off;
    int  unit;
    int  grp;
    int  m;
    logic act;
    logic vb;
    p     = int'(pos) + SLOT;
    lin   = int'(line);
    act   = video && (lin < V_ACT);
    vb    = !video || (lin >= V_ACT - 1);
    sym   = '0;
    bs_ev = 1'b0;
    be_ev = 1'b0;
    sr_ev = 1'b0;
    off   = 0;
    unit  = 0;
    grp   = 0;
    m     = 0;
    if (act && p == 0) begin
      sym   = kcode(K_BE);
      be_ev = 1'b1;
    end else if (act && p < BS_POS) begin
      unit = (p - 1) / TU_SYMS;
      off  = (p - 1) % TU_SYMS;
      if (off < TU_DATA)             sym.d = pix_byte(unit * TU_PIX + off / 3, lin, off % 3);
      else if (off == TU_DATA)       sym   = kcode(K_FS);
      else if (off == TU_SYMS - 1)   sym   = kcode(K_FE);
    end else if (p == BS_POS) begin
      sym   = kcode(sr_now ? K_SR : K_BS);
      bs_ev = 1'b1;
      sr_ev = sr_now;
    end else if (p > BS_POS && p < GRP_END) begin
      grp = (p - BS_POS - 1) / VB_REP;
      case (grp)
        0:       sym.d = {4'b0000, !video, 2'b00, vb};
        1:       sym.d = video ? MVID[7:0] : 8'h00;
        default: sym.d = 8'h00;
      endcase
    end else if (video && lin == V_ACT && p >= GRP_END && p < MSA_END) begin
      m = p - GRP_END;
      if (m < 2)                   sym   = kcode(K_SS);
      else if (m == MSA_SYMS - 1)  sym   = kcode(K_SE);
      else                         sym.d = msa_byte(m - 2);
    end
  end

endmodule

// File: rtl/dpf_stream_framer.sv
module dpf_stream_framer
  import dpf_pkg::*;
#(
  parameter int          H_ACT    = 800,
  parameter int          V_ACT    = 600,
  parameter int          H_TOT    = 1056,
  parameter int          H_SW     = 128,
  parameter int          H_BP     = 88,
  parameter bit          H_POL    = 1'b0,
  parameter int          V_TOT    = 628,
  parameter int          V_SW     = 4,
  parameter int          V_BP     = 23,
  parameter bit          V_POL    = 1'b0,
  parameter int          LINE_SYM = 7128,
  parameter int          IDLE_CYC = 65536,
  parameter int          SR_EVERY = 512,
  parameter logic [23:0] MVID     = 24'h012F68,
  parameter logic [23:0] NVID     = 24'h080000,
  parameter logic [7:0]  MISC0    = 8'h21,
  parameter logic [7:0]  MISC1    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  output logic [7:0] sym_lo,
  output logic       k_lo,
  output logic [7:0] sym_hi,
  output logic       k_hi
);

  localparam int PW = $clog2(LINE_SYM);
  localparam int LW = $clog2(V_TOT);

  logic [PW-1:0] pos;
  logic [LW-1:0] line_idx;
  logic          video_on;
  logic          sr_now;
  sym_t          slot_sym [2];
  logic [1:0]    bs_slot;
  logic [1:0]    be_slot;
  logic [1:0]    sr_slot;
  logic          bs_ev;
  logic          be_ev;
  logic          sr_ev;

  assign bs_ev = |bs_slot;
  assign be_ev = |be_slot;
  assign sr_ev = |sr_slot;

  dpf_timebase #(
    .LINE_SYM(LINE_SYM), .V_TOT(V_TOT), .IDLE_CYC(IDLE_CYC)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .pos(pos), .line(line_idx), .video(video_on)
  );

  dpf_sr_track #(.SR_EVERY(SR_EVERY)) u_sr (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .bs_any(bs_ev), .sr_now(sr_now)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slot
    dpf_slot_gen #(
      .SLOT(g), .H_ACT(H_ACT), .V_ACT(V_ACT), .H_TOT(H_TOT), .H_SW(H_SW),
      .H_BP(H_BP), .H_POL(H_POL), .V_TOT(V_TOT), .V_SW(V_SW), .V_BP(V_BP),
      .V_POL(V_POL), .LINE_SYM(LINE_SYM), .MVID(MVID), .NVID(NVID),
      .MISC0(MISC0), .MISC1(MISC1)
    ) u_gen (
      .pos(pos), .line(line_idx), .video(video_on), .sr_now(sr_now),
      .sym(slot_sym[g]), .bs_ev(bs_slot[g]), .be_ev(be_slot[g]),
      .sr_ev(sr_slot[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_lo <= 8'h00;
      k_lo   <= 1'b0;
      sym_hi <= 8'h00;
      k_hi   <= 1'b0;
    end else begin
      sym_lo <= slot_sym[0].d;
      k_lo   <= slot_sym[0].k;
      sym_hi <= slot_sym[1].d;
      k_hi   <= slot_sym[1].k;
    end
  end

endmodule

// File: rtl/dpf_framer_chk.sv
module dpf_framer_chk #(
  parameter int V_ACT    = 600,
  parameter int SR_EVERY = 512,
  parameter int LW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_up,
  input logic [7:0]    sym_lo,
  input logic          k_lo,
  input logic [7:0]    sym_hi,
  input logic          k_hi,
  input logic          video_on,
  input logic [LW-1:0] line_idx,
  input logic          bs_ev,
  input logic          be_ev,
  input logic          sr_ev
);

  int bs_since_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bs_since_sr <= 0;
    else if (!link_up) bs_since_sr <= 0;
    else if (sr_ev)    bs_since_sr <= 0;
    else if (bs_ev)    bs_since_sr <= bs_since_sr + 1;
  end

  // R3: blanking-end is only produced once video has started
  a_r3_be_needs_video: assert property (@(posedge clk) disable iff (!rst_n)
    be_ev |-> video_on);

  // R6: blanking-end never on a vertical blanking line
  a_r6_no_be_in_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    be_ev |-> (int'(line_idx) < V_ACT));

  // R4: scrambler reset exactly at the SR_EVERY-th blanking start
  a_r4_sr_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ev |-> (bs_since_sr == SR_EVERY - 1));

  a_r4_bs_not_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_ev && !sr_ev) |-> (bs_since_sr != SR_EVERY - 1));

  // R11: K flag only with a legal control code
  a_r11_k_lo_legal: assert property (@(posedge clk) disable iff (!rst_n)
    k_lo |-> (sym_lo inside {8'hBC, 8'hFB, 8'h1C, 8'hFE, 8'hF7, 8'h5C, 8'hFD}));

  a_r11_k_hi_legal: assert property (@(posedge clk) disable iff (!rst_n)
    k_hi |-> (sym_hi inside {8'hBC, 8'hFB, 8'h1C, 8'hFE, 8'hF7, 8'h5C, 8'hFD}));

  // R12: two cycles after link loss, the output is quiet
  a_r12_quiet_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> ##2 (!k_lo && !k_hi && sym_lo == 8'h00 && sym_hi == 8'h00));

endmodule

bind dpf_stream_framer dpf_framer_chk #(
  .V_ACT(V_ACT), .SR_EVERY(SR_EVERY), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up),
  .sym_lo(sym_lo), .k_lo(k_lo), .sym_hi(sym_hi), .k_hi(k_hi),
  .video_on(video_on), .line_idx(line_idx),
  .bs_ev(bs_ev), .be_ev(be_ev), .sr_ev(sr_ev)
);

// File: tb/sim_dpf_stream_framer.sv
module sim_dpf_stream_framer;

  localparam int HA = 16, VA = 3, HT = 20, HSW = 2, HBP = 1;
  localparam int VT = 6, VSW = 1, VBP = 1, LS = 160, IDLE = 200, SRE = 4;
  localparam logic [23:0] MV = 24'h012F68;
  localparam logic [23:0] NV = 24'h080000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic [7:0] sym_lo, sym_hi;
  logic k_lo, k_hi;

  int n_run = 0;
  int n_fail = 0;
  int bs_seen = 0;
  bit done = 1'b0;
  logic [7:0] msa [24];

  always #10 clk = ~clk;

  dpf_stream_framer #(
    .H_ACT(HA), .V_ACT(VA), .H_TOT(HT), .H_SW(HSW), .H_BP(HBP), .H_POL(1'b1),
    .V_TOT(VT), .V_SW(VSW), .V_BP(VBP), .V_POL(1'b0), .LINE_SYM(LS),
    .IDLE_CYC(IDLE), .SR_EVERY(SRE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .sym_lo(sym_lo), .k_lo(k_lo), .sym_hi(sym_hi), .k_hi(k_hi)
  );

  task automatic chk(input logic ak, input logic [7:0] ad, input logic ek,
                     input logic [7:0] ed, input string tag, input string what);
    n_run++;
    if (ak !== ek || ad !== ed) begin
      n_fail++;
      $display("FAIL %s %s: got k=%0b d=%02h, expected k=%0b d=%02h",
               tag, what, ak, ad, ek, ed);
    end
  endtask

  // expected symbol for state index s (cycles since restart), slot 0/1
  task automatic model(input int s, input int slot, output logic ek,
                       output logic [7:0] ed, output string tag, output bit isbs);
    int lpc, first_v, t, ln, p, bsp, u, r, px, g, m;
    bit vid;
    lpc = LS / 2;
    first_v = IDLE + (((lpc - 1 - (IDLE % lpc)) % lpc) + lpc) % lpc + 1;
    if (s < first_v) begin
      vid = 0; ln = 0; p = (s % lpc) * 2 + slot;
    end else begin
      t = s - first_v; vid = 1; ln = (t / lpc) % VT; p = (t % lpc) * 2 + slot;
    end
    bsp = 1 + (HA / 8) * 54;
    ek = 0; ed = 8'h00; isbs = 0;
    tag = vid ? "R11" : "R2";
    if (vid && ln < VA && p == 0) begin
      ek = 1; ed = 8'hFB; tag = (ln == 0) ? "R3" : "R6";
    end else if (vid && ln < VA && p < bsp) begin
      u = (p - 1) / 54; r = (p - 1) - u * 54;
      if (r < 24) begin
        px = u * 8 + r / 3; tag = "R8";
        case (r - 3 * (r / 3))
          0: ed = 8'(px);
          1: ed = 8'(ln);
          default: ed = 8'(px) ^ 8'(ln);
        endcase
      end else if (r == 24) begin ek = 1; ed = 8'hFE; tag = "R7"; end
      else if (r == 53) begin ek = 1; ed = 8'hF7; tag = "R7"; end
      else tag = "R7";
    end else if (p == bsp) begin
      isbs = 1; ek = 1; tag = "R4";
    end else if (p > bsp && p <= bsp + 12) begin
      g = (p - bsp - 1) / 4;
      if (g == 0) begin
        ed = vid ? ((ln >= VA - 1) ? 8'h01 : 8'h00) : 8'h09;
        tag = vid ? "R6" : "R2";
      end else if (g == 1) begin
        ed = vid ? MV[7:0] : 8'h00; tag = vid ? "R5" : "R2";
      end else tag = vid ? "R5" : "R2";
    end else if (vid && ln == VA && p >= bsp + 13 && p < bsp + 40) begin
      m = p - bsp - 13;
      if (m < 2) begin ek = 1; ed = 8'h5C; tag = "R9"; end
      else if (m == 26) begin ek = 1; ed = 8'hFD; tag = "R9"; end
      else begin
        ed = msa[m - 2];
        tag = ((m - 2) <= 2 || ((m - 2) >= 9 && (m - 2) <= 12) || (m - 2) >= 19) ? "R10" : "R9";
      end
    end
  endtask

  task automatic sweep(input int ncyc);
    logic ek;
    logic [7:0] ed;
    string tag;
    bit isbs;
    for (int j = 0; j < ncyc; j++) begin
      @(negedge clk);
      for (int sl = 0; sl < 2; sl++) begin
        model(j, sl, ek, ed, tag, isbs);
        if (isbs) begin
          ed = ((bs_seen % SRE) == SRE - 1) ? 8'h1C : 8'hBC;
          bs_seen++;
        end
        if (sl == 0) chk(k_lo, sym_lo, ek, ed, tag, $sformatf("cyc %0d lo", j));
        else         chk(k_hi, sym_hi, ek, ed, tag, $sformatf("cyc %0d hi", j));
      end
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    msa = '{MV[23:16], MV[15:8], MV[7:0],
            8'(HT >> 8), 8'(HT), 8'(VT >> 8), 8'(VT),
            8'h80 | 8'(HSW >> 8), 8'(HSW),
            8'((HSW + HBP) >> 8), 8'(HSW + HBP),
            8'((VSW + VBP) >> 8), 8'(VSW + VBP),
            8'(VSW >> 8), 8'(VSW),
            8'(HA >> 8), 8'(HA), 8'(VA >> 8), 8'(VA),
            NV[23:16], NV[15:8], NV[7:0], 8'h21, 8'h00};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(k_lo, sym_lo, 1'b0, 8'h00, "R1", "reset lo");
    chk(k_hi, sym_hi, 1'b0, 8'h00, "R1", "reset hi");
    rst_n = 1'b1;
    link_up = 1'b1;
    // idle, handover and two full frames
    sweep(1210);
    // R12: link drop in mid frame
    link_up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(k_lo, sym_lo, 1'b0, 8'h00, "R12", "drop lo");
    chk(k_hi, sym_hi, 1'b0, 8'h00, "R12", "drop hi");
    @(negedge clk);
    chk(k_lo, sym_lo, 1'b0, 8'h00, "R12", "drop lo 2");
    chk(k_hi, sym_hi, 1'b0, 8'h00, "R12", "drop hi 2");
    link_up = 1'b1;
    bs_seen = 0;
    sweep(560);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end, expected end before 200000 cycles");
      report();
    end
  end

endmodule